// File: doc/BRIEF.md
# Asynchronous Static RAM Sequencer

This block sits between a synchronous host and an external asynchronous static RAM of 131,072 bytes. The host hands it one read or write at a time over a valid/ready port. The block turns each request into the chip-enable, write-enable and output-enable pattern the memory needs. Every phase length is a whole number of clock cycles set by a parameter. The defaults suit a 100 MHz clock and a memory with a 10 ns access time. Read data comes back on a one-cycle response strobe.

The memory's bidirectional data pins are modelled as three signals: a driven byte, a received byte and a drive enable. The block enables its drivers only while a write strobe is active, and it keeps output enable high for the whole of every write. After a read it holds off any write for a programmable number of idle cycles. This gives the memory time to release the bus before the block drives it.

Top module: `sram_ctl`

## Requirements
- R1: While reset is held and after it is released, chip enable, write enable and output enable are all high (inactive), the drive enable and the response strobe are low, and the block is ready for a request.
- R2: A request is taken on a clock edge where req_valid and req_ready are both high. Its address is registered at that edge and appears on mem_addr. mem_addr stays unchanged for as long as chip enable stays low.
- R3: A write holds chip enable and write enable low together for WE_CYC cycles, starting the cycle after acceptance, with output enable high throughout. Chip enable and write enable then return high in the same cycle.
- R4: mem_dq_oe is high exactly while the write strobe is low, and mem_dq_out then carries the accepted write byte. It is never high while the memory drives the bus (chip enable low, output enable low, write enable high).
- R5: A read holds chip enable and output enable low with write enable high for RD_CYC cycles, starting the cycle after acceptance. In the following cycle rsp_valid is high for exactly one cycle, rsp_rdata holds the byte present on mem_dq_in at the end of the read, and output enable is high again.
- R6: In the TURN_CYC cycles after a read response begins, req_ready is low while req_write is high. A write presented then is taken once that gap has passed.
- R7: req_ready is low while an access is in progress, so only one request is outstanding. Chip enable is high for at least one cycle between two accesses.
- R8: A read presented during the response cycle of an earlier read is accepted in that same cycle, and both reads return their own bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block can take the request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_rdata | output | 8 | Read byte |
| mem_addr | output | 17 | Memory address |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_dq_out | output | 8 | Byte driven onto the data bus |
| mem_dq_in | input | 8 | Byte received from the data bus |
| mem_dq_oe | output | 1 | Data bus drive enable |

## Verification
Two events can fall in the same cycle: a read response, and the acceptance of the next request. In that cycle the turnaround gate must refuse a write but take a read. The bench provokes both cases from the response cycle of a read. First it presents a write and expects req_ready low, then high one cycle later. Then it presents a read and expects req_ready and rsp_valid high together. Each read's byte is judged against a behavioural memory model in the bench, and that model flags any cycle in which both sides would drive the bus.

// File: rtl/sram_ctl.sv
module sram_ctl #(
  parameter int AW       = 17,
  parameter int DW       = 8,
  parameter int WE_CYC   = 1,
  parameter int RD_CYC   = 2,
  parameter int TURN_CYC = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [DW-1:0] mem_dq_out,
  input  logic [DW-1:0] mem_dq_in,
  output logic          mem_dq_oe
);

  localparam int MAXC = (WE_CYC > RD_CYC) ? WE_CYC : RD_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam int TW   = $clog2(TURN_CYC + 2);

  typedef enum logic [1:0] {S_IDLE, S_WR, S_RD} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [TW-1:0] turn;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          rsp_q, ce_q, we_q, oe_q, doe_q;

  assign req_ready  = (st == S_IDLE) && !(req_write && turn != '0);
  assign rsp_valid  = rsp_q;
  assign rsp_rdata  = rdata_q;
  assign mem_addr   = addr_q;
  assign mem_ce_n   = ce_q;
  assign mem_we_n   = we_q;
  assign mem_oe_n   = oe_q;
  assign mem_dq_out = wdata_q;
  assign mem_dq_oe  = doe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      turn    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      rsp_q   <= 1'b0;
      ce_q    <= 1'b1;
      we_q    <= 1'b1;
      oe_q    <= 1'b1;
      doe_q   <= 1'b0;
    end else begin
      rsp_q <= 1'b0;
      case (st)
        S_IDLE: begin
          if (turn != '0) turn <= turn - 1'b1;
          if (req_valid && req_ready) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            ce_q    <= 1'b0;
            if (req_write) begin
              st    <= S_WR;
              we_q  <= 1'b0;
              doe_q <= 1'b1;
              cnt   <= CW'(WE_CYC - 1);
            end else begin
              st    <= S_RD;
              oe_q  <= 1'b0;
              cnt   <= CW'(RD_CYC - 1);
            end
          end
        end
        S_WR: begin
          if (cnt == '0) begin
            st    <= S_IDLE;
            ce_q  <= 1'b1;
            we_q  <= 1'b1;
            doe_q <= 1'b0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_RD: begin
          if (cnt == '0) begin
            st      <= S_IDLE;
            ce_q    <= 1'b1;
            oe_q    <= 1'b1;
            rdata_q <= mem_dq_in;
            rsp_q   <= 1'b1;
            turn    <= TW'(TURN_CYC);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_ready_only_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mem_ce_n);

  assert_we_inside_ce_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n));

  assert_drive_only_in_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_we_n && mem_oe_n));

  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

  assert_rsp_after_oe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!mem_oe_n));

  assert_rsp_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_turnaround_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> ($past(mem_oe_n) && $past(mem_oe_n, 2)));

endmodule

// File: tb/sram_ctl_bench.sv
module sram_ctl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WE_CYC   = 1;
  localparam int RD_CYC   = 2;
  localparam int TURN_CYC = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_valid, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  rsp_rdata, mem_dq_out, mem_dq_in;
  logic [16:0] mem_addr;
  logic [7:0]  mem [64];
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_ctl #(.AW(17), .DW(8), .WE_CYC(WE_CYC), .RD_CYC(RD_CYC), .TURN_CYC(TURN_CYC)) u_sram_ctl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe));

  assign mem_dq_in = (!mem_ce_n && !mem_oe_n && mem_we_n) ? mem[mem_addr[5:0]] : 8'h00;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !mem_ce_n && !mem_we_n) begin
      if (!mem_dq_oe) begin
        errors++;
        $display("FAIL R4: write strobe without drive, actual %0h expected 1", mem_dq_oe);
      end
      mem[mem_addr[5:0]] <= mem_dq_out;
    end
    if (rst_n && mem_dq_oe && !mem_ce_n && !mem_oe_n && mem_we_n) begin
      errors++;
      $display("FAIL R4: bus contention, actual %0h expected 0", mem_dq_oe);
    end
  end

  task automatic issue(input bit wr, input logic [16:0] a, input logic [7:0] d);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_valid, "R1 in reset",
        {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, rsp_valid}, 5'b11100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_valid, "R1 after reset",
        {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, rsp_valid}, 5'b11100);
    chk(req_ready, "R1 ready", req_ready, 1);
  endtask

  task automatic wr_follow(input logic [16:0] a, input logic [7:0] d);
    for (int i = 0; i < WE_CYC; i++) begin
      chk(!mem_ce_n && !mem_we_n && mem_oe_n, "R3 write strobe",
          {mem_ce_n, mem_we_n, mem_oe_n}, 3'b001);
      chk(mem_dq_oe && mem_dq_out == d, "R4 write drive", {mem_dq_oe, mem_dq_out}, {1'b1, d});
      chk(mem_addr == a, "R2 address", mem_addr, a);
      chk(!req_ready, "R7 busy", req_ready, 0);
      @(negedge clk);
    end
    chk(mem_ce_n && mem_we_n && !mem_dq_oe, "R3 write end",
        {mem_ce_n, mem_we_n, mem_dq_oe}, 3'b110);
  endtask

  task automatic t_write(input logic [16:0] a, input logic [7:0] d);
    issue(1'b1, a, d);
    wr_follow(a, d);
  endtask

  task automatic rd_follow(input logic [16:0] a, input logic [7:0] exp);
    for (int i = 0; i < RD_CYC; i++) begin
      chk(!mem_ce_n && !mem_oe_n && mem_we_n && !mem_dq_oe, "R5 read phase",
          {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b0010);
      chk(mem_addr == a && !rsp_valid && !req_ready, "R7 read busy",
          {rsp_valid, req_ready}, 0);
      @(negedge clk);
    end
    chk(rsp_valid && rsp_rdata == exp, "R5 response", {rsp_valid, rsp_rdata}, {1'b1, exp});
    chk(mem_oe_n && mem_ce_n, "R5 output enable released", {mem_ce_n, mem_oe_n}, 2'b11);
  endtask

  task automatic t_read(input logic [16:0] a, input logic [7:0] exp);
    issue(1'b0, a, 8'h00);
    rd_follow(a, exp);
  endtask

  task automatic t_turnaround;
    t_read(17'h10005, 8'h5A);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h00021; req_wdata = 8'h77;
    #1;
    chk(!req_ready, "R6 write held in gap", req_ready, 0);
    for (int i = 1; i < TURN_CYC; i++) begin
      @(negedge clk);
      chk(!req_ready, "R6 write held in gap", req_ready, 0);
    end
    @(negedge clk);
    chk(req_ready, "R6 write taken after gap", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    wr_follow(17'h00021, 8'h77);
  endtask

  task automatic t_back_to_back;
    t_read(17'h00012, 8'hC3);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 17'h00021;
    #1;
    chk(req_ready && rsp_valid, "R8 accept with response", {req_ready, rsp_valid}, 2'b11);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!rsp_valid, "R5 single strobe", rsp_valid, 0);
    rd_follow(17'h00021, 8'h77);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 8'h00;
    t_reset();
    t_write(17'h10005, 8'h5A);
    t_write(17'h00012, 8'hC3);
    t_turnaround();
    t_back_to_back();
    t_read(17'h10005, 8'h5A);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule